// File: doc/BRIEF.md
# Dual-Mode ROM/RAM Bank Controller

This block sits between a CPU's 16-bit address bus and a cartridge's ROM and external RAM. A CPU write that lands in the ROM window (0x0000-0x7FFF) cannot change the ROM. The block treats it as an update to one of four control registers, and bits 14:13 of the address pick the register. From those registers and the live address, the block forms a banked ROM address and a banked RAM address. It also gates every RAM access on a software-controlled enable.

A single mode bit decides what a 2-bit secondary register does. In mode 0 the register supplies bank bits 6:5 of the switchable ROM window (0x4000-0x7FFF), and external RAM stays on bank 0. In mode 1 the register selects one of four 8 KB RAM banks, and the ROM bank is limited to its low five bits. The 5-bit ROM bank register never holds zero, because a written zero is stored as one. The full ROM bank number is cut down to the configured ROM size, so banks beyond that size alias onto lower ones.

All outputs are combinational functions of the registers and the current address, so a lookup adds no latency. Register updates take effect on the clock edge that samples the write strobe.

Top module: `mbc_bank_ctrl`

## Requirements
- R1: After reset, RAM access is disabled, the mode bit is 0, and the ROM-low, secondary and enable registers are all 0. An address of 0x4000 therefore maps to ROM address 0.
- R2: A write to 0x0000-0x1FFF with data exactly 0x0A enables RAM access. Any other data value disables it.
- R3: A write to 0x2000-0x3FFF loads data bits 4:0 into the ROM-low register. While A14 is 1, rom_addr equals {bank, A[13:0]} and the bank's bits 4:0 come from this register.
- R4: A ROM-low value whose five bits are 00000 (for example data 0x00 or 0x60) is stored as 00001.
- R5: A write to 0x4000-0x5FFF loads data bits 1:0 into the secondary register. In mode 0, that register forms ROM bank bits 6:5 when A14 is 1. When A14 is 0 (fixed window, 0x0000-0x3FFF), the whole bank field is 0 in either mode.
- R6: A write to 0x6000-0x7FFF loads the mode bit from data bit 0. In mode 1, ROM bank bits 6:5 are 0 and ram_addr equals {secondary[1:0], A[12:0]}.
- R7: In mode 0, the RAM bank bits of ram_addr are 0.
- R8: Changing the mode bit leaves the secondary register unchanged. Returning to mode 0 restores the earlier ROM bank bits 6:5.
- R9: While RAM is disabled, an access to 0xA000-0xBFFF keeps ram_cs and ram_we low and returns 0xFF on cpu_rdata. While RAM is enabled, the access raises ram_cs, passes ram_rdata through, and asserts ram_we during a write.
- R10: The ROM bank is masked to ROM_BANK_W bits. With ROM_BANK_W = 6, bank bit 6 is dropped, so secondary value 3 in mode 0 gives the same bank as value 1.
- R11: Writes with A15 = 1, including writes into the RAM window, change none of the control registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising edge |
| ram_rdata | input | 8 | Data returned by the external RAM |
| rom_addr | output | ROM_BANK_W+14 | Banked ROM address |
| ram_addr | output | RAM_BANK_W+13 | Banked external RAM address |
| ram_cs | output | 1 | External RAM select (RAM window access while enabled) |
| ram_we | output | 1 | External RAM write enable |
| cpu_rdata | output | 8 | RAM-window read data, 0xFF while RAM is disabled |

The strobe is the only handshake. Every write is accepted in the cycle it is presented, and the block never applies back-pressure.

## Verification
The bound checker verifies, on every cycle, the properties that hold for every address:
- the fixed window always maps to bank 0;
- the ROM-low register never holds zero after a write to it;
- a RAM write or read while RAM is disabled is blocked;
- mode writes leave the secondary register alone;
- writes above 0x7FFF are ignored;
- in mode 1, the RAM bank bits follow the secondary register.

The directed scenarios cover what needs specific values:
- the exact 0x0A key versus a near miss such as 0x1A;
- zero remapping of data 0x60, where only the low five bits are zero;
- how the secondary bits combine with the low bank in each mode;
- aliasing of bank bit 6 in a 6-bit ROM configuration.

// File: rtl/mbc_bank_pkg.sv
package mbc_bank_pkg;

  // Control register picked by address bits 14:13 inside 0x0000-0x7FFF
  typedef enum logic [1:0] {
    SEL_RAM_GATE = 2'd0,
    SEL_ROM_LOW  = 2'd1,
    SEL_UPPER    = 2'd2,
    SEL_MODE     = 2'd3
  } reg_sel_e;

  localparam logic [7:0] RAM_UNLOCK_KEY = 8'h0A;
  localparam int         ROM_OFF_W      = 14;
  localparam int         RAM_OFF_W      = 13;
  localparam int         LOW_BANK_W     = 5;
  localparam int         FULL_BANK_W    = 7;
  localparam logic [2:0] RAM_WIN_TAG    = 3'b101;

  typedef struct packed {
    logic                  ram_gate;
    logic                  mode;
    logic [1:0]            upper;
    logic [LOW_BANK_W-1:0] rom_low;
  } bank_regs_t;

endpackage

// File: rtl/mbc_reg_file.sv
module mbc_reg_file
  import mbc_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr_hi,
  input  logic [7:0] wdata,
  input  logic       wr,
  output bank_regs_t regs_q
);

  reg_sel_e              sel;
  logic                  in_ctrl_space;
  logic [LOW_BANK_W-1:0] low_fixed;

  assign in_ctrl_space = wr & ~addr_hi[2];
  assign sel           = reg_sel_e'(addr_hi[1:0]);
  // A low bank field of zero is never stored
  assign low_fixed     = (wdata[LOW_BANK_W-1:0] == '0) ? LOW_BANK_W'(1)
                                                       : wdata[LOW_BANK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (in_ctrl_space) begin
      unique case (sel)
        SEL_RAM_GATE: regs_q.ram_gate <= (wdata == RAM_UNLOCK_KEY);
        SEL_ROM_LOW:  regs_q.rom_low  <= low_fixed;
        SEL_UPPER:    regs_q.upper    <= wdata[1:0];
        SEL_MODE:     regs_q.mode     <= wdata[0];
        default:      regs_q          <= regs_q;
      endcase
    end
  end

endmodule

// File: rtl/mbc_rom_map.sv
module mbc_rom_map
  import mbc_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 7
) (
  input  logic                  mode,
  input  logic [1:0]            upper,
  input  logic [LOW_BANK_W-1:0] rom_low,
  input  logic [ROM_OFF_W:0]    addr,
  output logic [ROM_BANK_W+ROM_OFF_W-1:0] rom_addr
);

  logic                   switchable;
  logic [1:0]             hi_bits;
  logic [LOW_BANK_W-1:0]  lo_bits;
  logic [FULL_BANK_W-1:0] full_bank;
  logic [ROM_BANK_W-1:0]  bank;

  assign switchable = addr[ROM_OFF_W];
  assign hi_bits    = (switchable && !mode) ? upper : 2'b00;
  assign lo_bits    = switchable ? rom_low : '0;
  assign full_bank  = {hi_bits, lo_bits};

  generate
    if (ROM_BANK_W >= FULL_BANK_W) begin : g_full
      assign bank = ROM_BANK_W'(full_bank);
    end else begin : g_masked
      assign bank = full_bank[ROM_BANK_W-1:0];
    end
  endgenerate

  assign rom_addr = {bank, addr[ROM_OFF_W-1:0]};

endmodule

// File: rtl/mbc_ram_map.sv
module mbc_ram_map
  import mbc_bank_pkg::*;
#(
  parameter int RAM_BANK_W = 2
) (
  input  logic        ram_gate,
  input  logic        mode,
  input  logic [1:0]  upper,
  input  logic [15:0] addr,
  input  logic        wr,
  input  logic [7:0]  ram_rdata,
  output logic [RAM_BANK_W+RAM_OFF_W-1:0] ram_addr,
  output logic        ram_cs,
  output logic        ram_we,
  output logic [7:0]  cpu_rdata
);

  logic                  in_window;
  logic [RAM_BANK_W-1:0] bank;

  assign in_window = (addr[15:13] == RAM_WIN_TAG);

  generate
    if (RAM_BANK_W >= 2) begin : g_wide
      assign bank = mode ? RAM_BANK_W'(upper) : '0;
    end else begin : g_narrow
      assign bank = mode ? upper[RAM_BANK_W-1:0] : '0;
    end
  endgenerate

  assign ram_addr  = {bank, addr[RAM_OFF_W-1:0]};
  assign ram_cs    = in_window & ram_gate;
  assign ram_we    = ram_cs & wr;
  assign cpu_rdata = ram_cs ? ram_rdata : 8'hFF;

endmodule

// File: rtl/mbc_bank_ctrl.sv
module mbc_bank_ctrl
  import mbc_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [15:0]                  cpu_addr,
  input  logic [7:0]                   cpu_wdata,
  input  logic                         cpu_wr,
  input  logic [7:0]                   ram_rdata,
  output logic [ROM_BANK_W+13:0]       rom_addr,
  output logic [RAM_BANK_W+12:0]       ram_addr,
  output logic                         ram_cs,
  output logic                         ram_we,
  output logic [7:0]                   cpu_rdata
);

  bank_regs_t regs_q;

  mbc_reg_file u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_hi (cpu_addr[15:13]),
    .wdata   (cpu_wdata),
    .wr      (cpu_wr),
    .regs_q  (regs_q)
  );

  mbc_rom_map #(.ROM_BANK_W(ROM_BANK_W)) u_rom (
    .mode     (regs_q.mode),
    .upper    (regs_q.upper),
    .rom_low  (regs_q.rom_low),
    .addr     (cpu_addr[ROM_OFF_W:0]),
    .rom_addr (rom_addr)
  );

  mbc_ram_map #(.RAM_BANK_W(RAM_BANK_W)) u_ram (
    .ram_gate  (regs_q.ram_gate),
    .mode      (regs_q.mode),
    .upper     (regs_q.upper),
    .addr      (cpu_addr),
    .wr        (cpu_wr),
    .ram_rdata (ram_rdata),
    .ram_addr  (ram_addr),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .cpu_rdata (cpu_rdata)
  );

endmodule

// File: rtl/mbc_bank_ctrl_chk.sv
module mbc_bank_ctrl_chk
  import mbc_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [15:0]            cpu_addr,
  input logic                   cpu_wr,
  input logic [7:0]             cpu_rdata,
  input logic [ROM_BANK_W+13:0] rom_addr,
  input logic [RAM_BANK_W+12:0] ram_addr,
  input logic                   ram_cs,
  input logic                   ram_we,
  input bank_regs_t             regs_q
);

  logic ram_window;
  assign ram_window = (cpu_addr[15:13] == RAM_WIN_TAG);

  // R5: the fixed window always uses bank 0
  p_fixed_bank_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> (rom_addr[ROM_BANK_W+13:14] == '0));

  // R4: after a write to the low bank register it is never zero
  p_low_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b001) |=> (regs_q.rom_low != '0));

  // R9: no RAM write without a select
  p_we_needs_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_cs);

  // R9: a disabled RAM reads as 0xFF
  p_disabled_reads_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_window && !regs_q.ram_gate) |-> (cpu_rdata == 8'hFF && !ram_cs));

  // R8: a mode write keeps the secondary register
  p_mode_keeps_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b011) |=> $stable(regs_q.upper));

  // R11: writes above 0x7FFF touch no register
  p_high_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15]) |=> $stable(regs_q));

  // R6: in mode 1 the RAM bank bits follow the secondary register
  p_mode1_ram_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_q.mode && ram_cs) |->
      (ram_addr[RAM_BANK_W+12:13] == regs_q.upper[RAM_BANK_W-1:0]));

endmodule

bind mbc_bank_ctrl mbc_bank_ctrl_chk #(
  .ROM_BANK_W(ROM_BANK_W),
  .RAM_BANK_W(RAM_BANK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_wr    (cpu_wr),
  .cpu_rdata (cpu_rdata),
  .rom_addr  (rom_addr),
  .ram_addr  (ram_addr),
  .ram_cs    (ram_cs),
  .ram_we    (ram_we),
  .regs_q    (regs_q)
);

// File: tb/mbc_bank_ctrl_tb_top.sv
module mbc_bank_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ROM_BW     = 6;
  localparam int RAM_BW     = 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [15:0]          addr = '0;
  logic [7:0]           wdata = '0;
  logic                 wr = 1'b0;
  logic [7:0]           ram_rdata = 8'h5A;
  logic [ROM_BW+13:0]   rom_addr;
  logic [RAM_BW+12:0]   ram_addr;
  logic                 ram_cs;
  logic                 ram_we;
  logic [7:0]           cpu_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbc_bank_ctrl #(.ROM_BANK_W(ROM_BW), .RAM_BANK_W(RAM_BW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (addr),
    .cpu_wdata (wdata),
    .cpu_wr    (wr),
    .ram_rdata (ram_rdata),
    .rom_addr  (rom_addr),
    .ram_addr  (ram_addr),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .cpu_rdata (cpu_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic peek(input logic [15:0] a);
    addr = a;
    #1;
  endtask

  function automatic logic [31:0] bank_of(input logic [ROM_BW+13:0] ra);
    return 32'(ra[ROM_BW+13:14]);
  endfunction

  task automatic t_reset;
    peek(16'h4000);
    check("R1 rom_addr at 0x4000", 32'(rom_addr), 32'h0);
    peek(16'hA000);
    check("R1 ram_cs after reset", 32'(ram_cs), 32'h0);
    check("R9 rdata while disabled", 32'(cpu_rdata), 32'hFF);
  endtask

  task automatic t_enable;
    do_wr(16'h0000, 8'h0A);
    peek(16'hA123);
    check("R2 ram_cs after key", 32'(ram_cs), 32'h1);
    check("R9 rdata passes when enabled", 32'(cpu_rdata), 32'h5A);
    do_wr(16'h1FFF, 8'h1A);
    peek(16'hA123);
    check("R2 near-miss disables", 32'(ram_cs), 32'h0);
    do_wr(16'h1000, 8'h0A);
    peek(16'hBFFF);
    check("R2 re-enable", 32'(ram_cs), 32'h1);
  endtask

  task automatic t_rom_low;
    do_wr(16'h2000, 8'h13);
    peek(16'h4567);
    check("R3 bank 0x13", bank_of(rom_addr), 32'h13);
    check("R3 offset kept", 32'(rom_addr[13:0]), 32'h0567);
    do_wr(16'h3FFF, 8'hE7);
    peek(16'h7FFF);
    check("R3 only low five bits", bank_of(rom_addr), 32'h07);
  endtask

  task automatic t_zero_remap;
    do_wr(16'h2000, 8'h00);
    peek(16'h4000);
    check("R4 zero becomes one", bank_of(rom_addr), 32'h01);
    do_wr(16'h2ABC, 8'h60);
    peek(16'h4000);
    check("R4 0x60 becomes one", bank_of(rom_addr), 32'h01);
  endtask

  task automatic t_mode0;
    do_wr(16'h4000, 8'h01);
    peek(16'h4000);
    check("R5 upper bits in switch window", bank_of(rom_addr), 32'h21);
    peek(16'h0100);
    check("R5 fixed window bank zero", bank_of(rom_addr), 32'h00);
    peek(16'hA010);
    check("R7 mode0 ram bank zero", 32'(ram_addr), 32'h0010);
  endtask

  task automatic t_alias;
    do_wr(16'h5FFF, 8'h03);
    peek(16'h4000);
    check("R10 bit6 aliased", bank_of(rom_addr), 32'h21);
  endtask

  task automatic t_mode1;
    do_wr(16'h6000, 8'h01);
    peek(16'h4000);
    check("R6 mode1 rom upper zero", bank_of(rom_addr), 32'h01);
    peek(16'hA010);
    check("R6 mode1 ram bank", 32'(ram_addr), 32'h6010);
    peek(16'h2000);
    check("R5 fixed window mode1", bank_of(rom_addr), 32'h00);
    do_wr(16'h7FFF, 8'hFE);
    peek(16'h4000);
    check("R8 upper kept over mode change", bank_of(rom_addr), 32'h21);
  endtask

  task automatic t_ignore_high;
    do_wr(16'hA000, 8'h00);
    do_wr(16'hC000, 8'h00);
    do_wr(16'h8000, 8'h00);
    peek(16'hA000);
    check("R11 RAM still enabled", 32'(ram_cs), 32'h1);
    peek(16'h4000);
    check("R11 bank unchanged", bank_of(rom_addr), 32'h21);
  endtask

  task automatic t_write_gate;
    @(negedge clk);
    addr = 16'hA004; wdata = 8'h11; wr = 1'b1;
    #1;
    check("R9 ram_we when enabled", 32'(ram_we), 32'h1);
    @(negedge clk);
    wr = 1'b0;
    do_wr(16'h0000, 8'h00);
    @(negedge clk);
    addr = 16'hA004; wr = 1'b1;
    #1;
    check("R9 ram_we blocked when disabled", 32'(ram_we), 32'h0);
    check("R9 rdata 0xFF when disabled", 32'(cpu_rdata), 32'hFF);
    @(negedge clk);
    wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_rom_low();
    t_zero_remap();
    t_mode0();
    t_alias();
    t_mode1();
    t_ignore_high();
    t_write_gate();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule